// File: doc/BRIEF.md
# Orbit Pulse Conditioning Channel

This block conditions one orbit-marker channel. It runs entirely on the bunch clock, and every timing value it takes is a count of bunch-clock ticks. A source switch chooses the orbit marker. The marker is either the rising edge of an external orbit signal, which arrives already latched on the bunch clock, or a pulse from an internal period counter. The chosen marker starts a coarse delay, and when the delay ends the block drives an output pulse of programmed width.

Alongside the shaping path, the block keeps a 32-bit tally of the selected orbits, which software clears with a command pulse. It also keeps a flag that says whether external orbits are arriving. The internal period counter can be read, so the tick position inside the self-generated orbit is visible. All configuration arrives on register inputs, and the tally, counter and flag leave as read-only outputs.

Top module: `orbit_channel`

## Requirements
- R1: After reset, `orbit_out` is 0, `orbit_tally` is 0, `int_count` is 0 and `orbit_present` is 0.
- R2: With `src_sel`=0 the selected orbit is a rising edge of `ext_orbit`, meaning the input is 1 at a clock edge and was 0 at the edge before it. `orbit_out` goes high D+1 clock edges after the edge that samples the orbit, where D is `coarse_delay`.
- R3: `orbit_out` stays high for W consecutive cycles, where W is `pulse_width`. A `pulse_width` of 0 gives a one-cycle pulse.
- R4: An orbit selected while a delay or a pulse is in progress restarts the delay from that orbit. `orbit_out` is 0 in the cycle after the restarting orbit.
- R5: With `src_sel`=1 the selected orbit is the internal one, and edges on `ext_orbit` are not counted. With `int_period`=P>0 loaded while the counter is at 0, an internal orbit occurs at edges P, 2P, 3P and so on. After N edges, `int_count` equals N mod P.
- R6: With `int_period`=0 the internal generator stops: `int_count` stays 0 and no internal orbit occurs.
- R7: `orbit_tally` increases by exactly 1 at each selected orbit. An `ext_orbit` held high for many cycles counts once.
- R8: `tally_clear`=1 at an edge sets `orbit_tally` to 0. This wins over an orbit selected at the same edge.
- R9: A rising edge of `ext_orbit` sets `orbit_present` at that edge, whatever `src_sel` is. The flag falls LOSS_TICKS edges (4096 by default) after the last external edge if no new edge arrives in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 1 | 0 = external orbit, 1 = internal orbit |
| ext_orbit | input | 1 | External orbit signal, already latched on the bunch clock |
| int_period | input | 12 | Internal orbit period in ticks; 0 stops the generator |
| coarse_delay | input | 12 | Delay from orbit to pulse, in ticks |
| pulse_width | input | 12 | Output pulse length in ticks; 0 means 1 |
| tally_clear | input | 1 | Clears the orbit tally |
| orbit_out | output | 1 | Delayed, shaped orbit pulse |
| int_count | output | 12 | Ticks since the last internal orbit |
| orbit_tally | output | 32 | Count of selected orbits |
| orbit_present | output | 1 | External orbit seen within the loss window |

## Verification
If the delay counter were loaded or decremented wrongly, the first pulse after an orbit would start at the wrong cycle, and that shows within D+2 cycles. A width counter fault changes the number of high cycles on `orbit_out` in that same pulse. A fault in the internal period counter shows in `int_count` and in the tally after a few periods. A fault in the presence watchdog shows only at the end of the 4096-tick loss window, so the bench waits through that whole window.

// File: rtl/orbit_pkg.sv
package orbit_pkg;
  localparam int CNT_W = 12;

  typedef enum logic [1:0] {PH_IDLE, PH_DELAY, PH_PULSE} shaper_phase_e;

  // A programmed width of 0 is stretched to a single tick.
  function automatic logic [CNT_W-1:0] eff_width(input logic [CNT_W-1:0] w);
    return (w == '0) ? CNT_W'(1) : w;
  endfunction

  // Internal period counter wraps once it reaches period-1.
  function automatic logic period_wrap(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] period);
    return (period != '0) && (cnt >= period - CNT_W'(1));
  endfunction
endpackage

// File: rtl/orbit_int_gen.sv
module orbit_int_gen
  import orbit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             int_pulse
);
  assign int_pulse = period_wrap(count, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (period == '0)   count <= '0;
    else if (int_pulse)      count <= '0;
    else                     count <= count + CNT_W'(1);
  end

  assert_stopped_gen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> !int_pulse);
  assert_stopped_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |=> (count == '0));
endmodule

// File: rtl/orbit_shaper.sv
module orbit_shaper
  import orbit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] delay,
  input  logic [CNT_W-1:0] width,
  output logic             pulse
);
  shaper_phase_e    phase;
  logic [CNT_W-1:0] dcnt;
  logic [CNT_W-1:0] wcnt;
  logic             delay_done;
  logic             width_done;

  assign delay_done = (phase == PH_DELAY) && (dcnt == '0);
  assign width_done = (phase == PH_PULSE) && (wcnt == '0);
  assign pulse      = (phase == PH_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      dcnt  <= '0;
      wcnt  <= '0;
    end else if (trig) begin
      phase <= PH_DELAY;
      dcnt  <= delay;
    end else if (delay_done) begin
      phase <= PH_PULSE;
      wcnt  <= eff_width(width) - CNT_W'(1);
    end else if (width_done) begin
      phase <= PH_IDLE;
    end else if (phase == PH_DELAY) begin
      dcnt <= dcnt - CNT_W'(1);
    end else if (phase == PH_PULSE) begin
      wcnt <= wcnt - CNT_W'(1);
    end
  end

  assert_restart_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !pulse);
  assert_pulse_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    width_done |=> !pulse);
  assert_rise_from_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(delay_done));
endmodule

// File: rtl/orbit_presence.sv
module orbit_presence #(
  parameter int LOSS_TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  output logic present
);
  localparam int LW = $clog2(LOSS_TICKS) + 1;
  localparam logic [LW-1:0] LAST = LW'(LOSS_TICKS - 1);

  logic [LW-1:0] quiet;
  logic          expire;

  assign expire = (quiet == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet   <= LAST;
      present <= 1'b0;
    end else if (edge_seen) begin
      quiet   <= '0;
      present <= 1'b1;
    end else if (expire) begin
      present <= 1'b0;
    end else begin
      quiet <= quiet + LW'(1);
    end
  end

  assert_edge_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> present);
  assert_loss_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !edge_seen) |=> !present);
endmodule

// File: rtl/orbit_channel.sv
module orbit_channel
  import orbit_pkg::*;
#(
  parameter int TALLY_W    = 32,
  parameter int LOSS_TICKS = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_sel,
  input  logic               ext_orbit,
  input  logic [CNT_W-1:0]   int_period,
  input  logic [CNT_W-1:0]   coarse_delay,
  input  logic [CNT_W-1:0]   pulse_width,
  input  logic               tally_clear,
  output logic               orbit_out,
  output logic [CNT_W-1:0]   int_count,
  output logic [TALLY_W-1:0] orbit_tally,
  output logic               orbit_present
);
  logic ext_q;
  logic ext_rise;
  logic int_pulse;
  logic sel_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_orbit;
  end

  assign ext_rise  = ext_orbit && !ext_q;
  assign sel_pulse = src_sel ? int_pulse : ext_rise;

  orbit_int_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .period    (int_period),
    .count     (int_count),
    .int_pulse (int_pulse)
  );

  orbit_shaper u_shape (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (sel_pulse),
    .delay (coarse_delay),
    .width (pulse_width),
    .pulse (orbit_out)
  );

  orbit_presence #(.LOSS_TICKS(LOSS_TICKS)) u_pres (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_seen (ext_rise),
    .present   (orbit_present)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           orbit_tally <= '0;
    else if (tally_clear) orbit_tally <= '0;
    else if (sel_pulse)   orbit_tally <= orbit_tally + TALLY_W'(1);
  end

  assert_tally_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pulse && !tally_clear) |=> (orbit_tally == $past(orbit_tally) + TALLY_W'(1)));
  assert_tally_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_pulse && !tally_clear) |=> $stable(orbit_tally));
  assert_tally_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tally_clear |=> (orbit_tally == '0));
  assert_ext_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && !int_pulse && !tally_clear) |=> $stable(orbit_tally));
endmodule

// File: tb/tb_orbit_channel.sv
module tb_orbit_channel;
  localparam int LOSS = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_sel = 1'b0;
  logic        ext_orbit = 1'b0;
  logic [11:0] int_period = '0;
  logic [11:0] coarse_delay = '0;
  logic [11:0] pulse_width = '0;
  logic        tally_clear = 1'b0;
  logic        orbit_out;
  logic [11:0] int_count;
  logic [31:0] orbit_tally;
  logic        orbit_present;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  orbit_channel dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_orbit(ext_orbit),
    .int_period(int_period), .coarse_delay(coarse_delay),
    .pulse_width(pulse_width), .tally_clear(tally_clear),
    .orbit_out(orbit_out), .int_count(int_count),
    .orbit_tally(orbit_tally), .orbit_present(orbit_present)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog R1: cycles %0d expected below 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One-cycle external pulse, then measure where orbit_out goes high
  task automatic ext_measure(input int d, input int w, output int first, output int nhigh);
    int span;
    ext_orbit = 1'b1;
    step();
    ext_orbit = 1'b0;
    first = -1;
    nhigh = 0;
    span = d + ((w == 0) ? 1 : w) + 4;
    for (int k = 0; k <= span; k++) begin
      if (orbit_out) begin
        if (first < 0) first = k;
        nhigh++;
      end
      if (k < span) step();
    end
  endtask

  initial begin
    int first, nhigh, weff;
    logic [31:0] t0;

    repeat (3) step();
    check(orbit_out == 1'b0, "R1 out", orbit_out, 0);
    check(orbit_tally == 0, "R1 tally", orbit_tally, 0);
    check(int_count == 0, "R1 int_count", int_count, 0);
    check(orbit_present == 1'b0, "R1 present", orbit_present, 0);
    rst_n = 1'b1;
    step();

    // R2 / R3 sweep of delay and width on the external source
    for (int d = 0; d <= 6; d++) begin
      for (int w = 0; w <= 4; w++) begin
        coarse_delay = 12'(d);
        pulse_width = 12'(w);
        step();
        t0 = orbit_tally;
        ext_measure(d, w, first, nhigh);
        weff = (w == 0) ? 1 : w;
        check(first == d + 1, "R2 rise offset", first, d + 1);
        check(nhigh == weff, "R3 width", nhigh, weff);
        check(orbit_tally == t0 + 1, "R7 tally per ext orbit", orbit_tally, t0 + 1);
      end
    end

    // R3 long delay case
    coarse_delay = 12'd3564;
    pulse_width = 12'd2;
    step();
    ext_measure(3564, 2, first, nhigh);
    check(first == 3565, "R2 long delay", first, 3565);
    check(nhigh == 2, "R3 long delay width", nhigh, 2);

    // R4 restart: second orbit 3 cycles after the first
    coarse_delay = 12'd5;
    pulse_width = 12'd3;
    step();
    ext_orbit = 1'b1; step(); ext_orbit = 1'b0;  // sample 0 after orbit A
    step(); step();                               // sample 2
    ext_orbit = 1'b1; step(); ext_orbit = 1'b0;  // sample 3 = orbit B
    first = -1; nhigh = 0;
    for (int k = 3; k <= 20; k++) begin
      if (orbit_out) begin
        if (first < 0) first = k;
        nhigh++;
      end
      step();
    end
    check(first == 9, "R4 restart rise", first, 9);
    check(nhigh == 3, "R4 restart width", nhigh, 3);

    // R7 held-high external signal counts once
    coarse_delay = 12'd0;
    pulse_width = 12'd1;
    step();
    t0 = orbit_tally;
    nhigh = 0;
    ext_orbit = 1'b1;
    for (int k = 0; k < 12; k++) begin
      step();
      if (orbit_out) nhigh++;
    end
    ext_orbit = 1'b0;
    step(); step();
    check(orbit_tally == t0 + 1, "R7 held level tally", orbit_tally, t0 + 1);
    check(nhigh == 1, "R7 held level pulses", nhigh, 1);

    // R9 presence window
    ext_orbit = 1'b1; step(); ext_orbit = 1'b0;  // sample 0
    check(orbit_present == 1'b1, "R9 set", orbit_present, 1);
    repeat (LOSS - 1) step();                      // sample LOSS-1
    check(orbit_present == 1'b1, "R9 still present", orbit_present, 1);
    step();                                        // sample LOSS
    check(orbit_present == 1'b0, "R9 loss", orbit_present, 0);

    // R5 internal period sweep, with external edges ignored
    src_sel = 1'b1;
    for (int p = 1; p <= 7; p++) begin
      int_period = 12'd0;
      tally_clear = 1'b1;
      step();
      tally_clear = 1'b0;
      step();
      check(orbit_tally == 0, "R8 clear", orbit_tally, 0);
      int_period = 12'(p);
      for (int n = 1; n <= 17; n++) begin
        ext_orbit = (n == 5);
        step();
        if (n == 8 || n == 17) begin
          check(orbit_tally == 32'(n / p), "R5 internal tally", orbit_tally, n / p);
          check(int_count == 12'(n % p), "R5 int_count", int_count, n % p);
        end
      end
      ext_orbit = 1'b0;
    end

    // R6 stopped generator
    int_period = 12'd0;
    step();
    t0 = orbit_tally;
    repeat (20) step();
    check(orbit_tally == t0, "R6 no internal orbit", orbit_tally, t0);
    check(int_count == 0, "R6 count held", int_count, 0);

    // R8 clear wins over a simultaneous orbit
    int_period = 12'd1;
    step(); step();
    tally_clear = 1'b1;
    step();
    check(orbit_tally == 0, "R8 clear priority", orbit_tally, 0);
    tally_clear = 1'b0;
    step();
    check(orbit_tally == 1, "R8 count resumes", orbit_tally, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule